// File: doc/BRIEF.md
# Privileged Interrupt Context Register Window

This block holds the 64-byte interrupt management context of one hardware thread. The context is four rings of 16 bytes: user at byte 0x00, OS at 0x10, pool at 0x20 and physical at 0x30. Software reaches the context through a memory-mapped window of four pages. Address bits [17:16] pick the page, and each page is a different privilege view of the same bytes: 0 hardware, 1 hypervisor, 2 OS, 3 user. A lower page number means more privilege. Every byte of every view carries a 2-bit access code: 0 none, 1 write only, 2 read only, 3 read/write.

A request is presented for one cycle with `req_valid`. It carries a write flag, a size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8) and an address. The block classifies the request into one of six response states. It answers exactly one cycle later with `rsp_valid`, the read data and an error flag.

Raw accesses read or write the register bytes directly, masked byte by byte through the view. Special operations are recognised by offset, size and direction:
- a 1-byte store at offset 0x011 sets the OS current priority;
- a 2-byte load at offset 0x810 is the OS acknowledge.

The state register follows these transitions on each clock edge:
- It loads `ST_IDLE` when no request is present.
- It loads `ST_ACK_RD` when the acknowledge operation matches.
- It loads `ST_PRIO_WR` when the priority store matches.
- It loads `ST_RAW_RD` or `ST_RAW_WR` when a raw access passes all checks.
- It loads `ST_REJ_RD` or `ST_REJ_WR` for anything else.

From every state, the next clock edge goes back to `ST_IDLE`, or into another response state if a new request arrives.

Top module: `irq_ctx_window`

## Requirements
- R1: Reset clears every context byte to 0x00, except bytes 0x13, 0x14 and 0x16, which become 0xFF; `rsp_valid`, `rsp_err` and `rsp_rdata` are low while the block is idle after reset.
- R2: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low after a cycle without a request.
- R3: Address bits [17:16] pick the view page. Bits [5:0] pick the first byte for raw access. Bits [15:12] and [10:6] are ignored. Different pages apply different permissions to the same byte.
- R4: A raw access must have size code 2 or 3 and be naturally aligned to its size; any other raw access is rejected with `rsp_err`.
- R5: A raw access whose first byte lies in the user ring (bits [5:4] = 0) is rejected.
- R6: A raw access in which no covered byte has the needed permission in the chosen view is rejected.
- R7: A rejected read returns all ones in `rsp_rdata`. A rejected write changes no byte. Every write response carries `rsp_rdata` = 0.
- R8: Read data is big-endian and right-justified. The lowest-addressed byte goes in the most significant lane of the access width, and upper unused lanes are zero. Lanes without read permission read as zero.
- R9: A raw write updates only the bytes with write permission; the other bytes keep their values.
- R10: With address bit 11 set, only special operations are looked up. A request there that matches none is rejected (all ones on reads), even if raw rules would allow it.
- R11: A special operation matches only when offset (address bits [11:0]), size and direction all agree. The page number must be less than or equal to the operation's page, which is 2 for both operations. An unmatched request below 0x800 falls back to the raw path.
- R12: A 1-byte write to offset 0x011 from pages 0–2 stores `req_wdata[7:0]` at byte 0x11, or stores 0xFF when the value exceeds MAX_PRIO (7). It responds without error.
- R13: A 2-byte read at offset 0x810 from pages 0–2 returns 0 without error and changes nothing.
- R14: View permissions:
  - User page: only byte 0x00 is accessible.
  - OS page:
    - byte 0x11 is read/write;
    - bytes 0x10, 0x12–0x15 and 0x17 are read only;
    - bytes 0x16 and 0x18–0x1F have no access;
    - user bytes 0x00 and 0x08–0x0B are read/write;
    - the pool and physical rings are closed.
  - Hypervisor page: same as hardware, except that byte 0x28 and bytes 0x3C–0x3E are closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| req_addr | input | ADDR_W (18) | Window address: page in [17:16], offset below |
| req_wdata | input | 64 | Store data, right-justified, big-endian |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Load data, right-justified, big-endian |
| rsp_err | output | 1 | Request was rejected |

## Verification
The bench uses the default parameters:
- an 18-bit address with the page field at bit 16, so all four views are reachable with plain constants;
- MAX_PRIO of 7, so the priority clamp can be probed on both sides of its edge (7 kept, 8 and 9 forced to 0xFF).

With these settings, aligned 8-byte accesses stay inside the 64-byte context. The same bytes are read through several pages to expose per-view masking. Aliased address bits and mid-run reset are also exercised.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

    localparam int CTX_BYTES  = 64;
    localparam int RING_BYTES = 16;
    localparam int RING_COUNT = CTX_BYTES / RING_BYTES;
    localparam int LANES      = 8;
    localparam int DATA_W     = LANES * 8;
    localparam int IDX_W      = $clog2(CTX_BYTES);
    localparam int RING_W     = $clog2(RING_COUNT);

    localparam logic [1:0] PG_HW  = 2'd0;
    localparam logic [1:0] PG_HV  = 2'd1;
    localparam logic [1:0] PG_OS  = 2'd2;
    localparam logic [1:0] PG_USR = 2'd3;

    localparam logic [1:0] PERM_NONE = 2'd0;
    localparam logic [1:0] PERM_WO   = 2'd1;
    localparam logic [1:0] PERM_RO   = 2'd2;
    localparam logic [1:0] PERM_RW   = 2'd3;

    localparam logic [1:0] SZ_1 = 2'd0;
    localparam logic [1:0] SZ_2 = 2'd1;
    localparam logic [1:0] SZ_4 = 2'd2;
    localparam logic [1:0] SZ_8 = 2'd3;

    // OS ring and the bytes inside it that matter to this block
    localparam int OS_RING_BASE = RING_BYTES;
    localparam int PRIO_IDX     = OS_RING_BASE + 1;

    // special operation table
    localparam int NUM_OPS = 2;
    localparam int OP_PRIO = 0;
    localparam int OP_ACK  = 1;
    localparam logic [11:0] OP_OFF  [NUM_OPS] = '{12'h011, 12'h810};
    localparam logic [1:0]  OP_PAGE [NUM_OPS] = '{PG_OS, PG_OS};
    localparam logic [1:0]  OP_SIZE [NUM_OPS] = '{SZ_1, SZ_2};
    localparam logic        OP_WR   [NUM_OPS] = '{1'b1, 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAW_RD,
        ST_RAW_WR,
        ST_ACK_RD,
        ST_PRIO_WR,
        ST_REJ_RD,
        ST_REJ_WR
    } win_state_t;

    // access code of one context byte seen through one page
    function automatic logic [1:0] view_perm(input logic [1:0] page, input int idx);
        int  ring;
        int  b;
        logic mid;
        logic phys_common;
        if (idx < 0 || idx >= CTX_BYTES) return PERM_NONE;
        ring = idx / RING_BYTES;
        b    = idx % RING_BYTES;
        mid  = (b >= 8) && (b <= 11);
        phys_common = (b <= 3) || (b == 5) || (b == 7) || (b == 8) || (b == 11);
        case (ring)
            0: begin
                if (page == PG_USR) return (b == 0) ? PERM_RW : PERM_NONE;
                return (b == 0 || mid) ? PERM_RW : PERM_NONE;
            end
            1: begin
                if (page <= PG_HV) return (b <= 5 || b == 7 || mid) ? PERM_RW : PERM_NONE;
                if (page == PG_OS) begin
                    if (b == 1) return PERM_RW;
                    if (b == 0 || (b >= 2 && b <= 5) || b == 7) return PERM_RO;
                end
                return PERM_NONE;
            end
            2: begin
                if (page == PG_HW) return (b == 2 || b == 3 || mid) ? PERM_RW : PERM_NONE;
                if (page == PG_HV)
                    return (b == 2 || b == 3 || (b >= 9 && b <= 11)) ? PERM_RW : PERM_NONE;
                return PERM_NONE;
            end
            3: begin
                if (page == PG_HW)
                    return (phys_common || (b >= 12 && b <= 14)) ? PERM_RW : PERM_NONE;
                if (page == PG_HV) return phys_common ? PERM_RW : PERM_NONE;
                return PERM_NONE;
            end
            default: return PERM_NONE;
        endcase
    endfunction

    function automatic logic [7:0] reset_byte(input int idx);
        if (idx == OS_RING_BASE + 3 || idx == OS_RING_BASE + 4 || idx == OS_RING_BASE + 6)
            return 8'hFF;
        return 8'h00;
    endfunction

endpackage

// File: rtl/ctx_lane_perm.sv
module ctx_lane_perm
    import irq_ctx_pkg::*;
(
    input  logic [1:0]       page,
    input  logic [IDX_W-1:0] base,
    output logic [LANES-1:0] rd_ok,
    output logic [LANES-1:0] wr_ok
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [1:0] code;
        assign code     = view_perm(page, int'(base) + i);
        assign rd_ok[i] = code[1];
        assign wr_ok[i] = code[0];
    end
endmodule

// File: rtl/ctx_op_match.sv
module ctx_op_match
    import irq_ctx_pkg::*;
(
    input  logic [1:0]         page,
    input  logic [11:0]        offset,
    input  logic [1:0]         size,
    input  logic               write,
    output logic [NUM_OPS-1:0] hit
);
    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        assign hit[k] = (offset == OP_OFF[k]) && (size == OP_SIZE[k]) &&
                        (write == OP_WR[k]) && (page <= OP_PAGE[k]);
    end
endmodule

// File: rtl/ctx_byte_store.sv
module ctx_byte_store
    import irq_ctx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       base,
    input  logic [LANES-1:0]       lane_we,
    input  logic [DATA_W-1:0]      lane_wd,
    input  logic                   prio_we,
    input  logic [7:0]             prio_val,
    output logic [CTX_BYTES*8-1:0] ctx_flat
);
    for (genvar b = 0; b < CTX_BYTES; b++) begin : g_byte
        localparam logic [7:0] RST_VAL = reset_byte(b);
        logic       hit;
        logic [7:0] d;
        logic [7:0] q;

        always_comb begin
            hit = 1'b0;
            d   = 8'h00;
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i] && (int'(base) + i == b)) begin
                    hit = 1'b1;
                    d   = lane_wd[8*i +: 8];
                end
            end
            if (prio_we && (b == PRIO_IDX)) begin
                hit = 1'b1;
                d   = prio_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RST_VAL;
            else if (hit) q <= d;
        end

        assign ctx_flat[8*b +: 8] = q;
    end
endmodule

// File: rtl/irq_ctx_window.sv
module irq_ctx_window
    import irq_ctx_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int PAGE_LSB = 16,
    parameter int MAX_PRIO = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int SPC_BIT = 11;

    win_state_t state_q, state_nxt;

    logic [1:0]             page;
    logic [11:0]            offset;
    logic [IDX_W-1:0]       base;
    logic [RING_W-1:0]      ring;
    logic                   spc_region;
    int                     n_bytes;
    logic                   wide;
    logic                   aligned;
    logic [LANES-1:0]       lane_act;
    logic [LANES-1:0]       rd_ok, wr_ok;
    logic [LANES-1:0]       rd_mask, wr_mask;
    logic [NUM_OPS-1:0]     op_hit;
    logic                   raw_pass;
    logic [LANES-1:0]       lane_we;
    logic [DATA_W-1:0]      lane_wd;
    logic                   prio_we;
    logic [7:0]             prio_val;
    logic [CTX_BYTES*8-1:0] ctx_flat;
    logic [DATA_W-1:0]      raw_rd;
    logic [DATA_W-1:0]      rd_q;
    logic                   addr_unused_bits;

    assign page       = req_addr[PAGE_LSB +: 2];
    assign offset     = req_addr[11:0];
    assign base       = req_addr[IDX_W-1:0];
    assign ring       = base[IDX_W-1 -: RING_W];
    assign spc_region = req_addr[SPC_BIT];
    assign addr_unused_bits = ^{req_addr[PAGE_LSB-1:12]};

    assign n_bytes = 1 << req_size;
    assign wide    = (req_size == SZ_4) || (req_size == SZ_8);
    assign aligned = (req_size == SZ_4) ? (base[1:0] == 2'b00) :
                     (req_size == SZ_8) ? (base[2:0] == 3'b000) : 1'b0;

    ctx_lane_perm u_perm (
        .page  (page),
        .base  (base),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    ctx_op_match u_ops (
        .page   (page),
        .offset (offset),
        .size   (req_size),
        .write  (req_write),
        .hit    (op_hit)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_act
        assign lane_act[i] = (i < n_bytes);
    end

    assign rd_mask  = lane_act & rd_ok;
    assign wr_mask  = lane_act & wr_ok;
    assign raw_pass = wide && aligned && (ring != '0) &&
                      (req_write ? (|wr_mask) : (|rd_mask));

    // request classification
    always_comb begin
        state_nxt = ST_IDLE;
        if (req_valid) begin
            if (op_hit[OP_ACK])                  state_nxt = ST_ACK_RD;
            else if (op_hit[OP_PRIO])            state_nxt = ST_PRIO_WR;
            else if (!spc_region && raw_pass)    state_nxt = req_write ? ST_RAW_WR : ST_RAW_RD;
            else                                 state_nxt = req_write ? ST_REJ_WR : ST_REJ_RD;
        end
    end

    // write lanes, big-endian: first byte from the top of the access width
    always_comb begin
        lane_wd = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < n_bytes) lane_wd[8*i +: 8] = req_wdata[8*(n_bytes-1-i) +: 8];
        end
    end

    assign lane_we  = (state_nxt == ST_RAW_WR) ? wr_mask : '0;
    assign prio_we  = (state_nxt == ST_PRIO_WR);
    assign prio_val = (req_wdata[7:0] > 8'(MAX_PRIO)) ? 8'hFF : req_wdata[7:0];

    ctx_byte_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (base),
        .lane_we  (lane_we),
        .lane_wd  (lane_wd),
        .prio_we  (prio_we),
        .prio_val (prio_val),
        .ctx_flat (ctx_flat)
    );

    // read lanes, masked by the view
    always_comb begin
        raw_rd = '0;
        for (int i = 0; i < LANES; i++) begin
            if (rd_mask[i])
                raw_rd[8*(n_bytes-1-i) +: 8] = ctx_flat[8*(int'(base)+i) +: 8];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_nxt;
            rd_q    <= raw_rd;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b1;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE:    rsp_valid = 1'b0;
            ST_RAW_RD:  rsp_rdata = rd_q;
            ST_RAW_WR:  rsp_rdata = '0;
            ST_ACK_RD:  rsp_rdata = '0;
            ST_PRIO_WR: rsp_rdata = '0;
            ST_REJ_RD: begin
                rsp_err   = 1'b1;
                rsp_rdata = '1;
            end
            ST_REJ_WR:  rsp_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/irq_ctx_window_chk.sv
module irq_ctx_window_chk
    import irq_ctx_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int PAGE_LSB = 16,
    parameter int MAX_PRIO = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic [7:0]        prio_byte
);
    logic [1:0] pg;
    logic       is_prio_op;
    logic       is_ack_op;

    assign pg         = req_addr[PAGE_LSB +: 2];
    assign is_prio_op = req_write && (req_size == SZ_1) &&
                        (req_addr[11:0] == OP_OFF[OP_PRIO]) && (pg <= OP_PAGE[OP_PRIO]);
    assign is_ack_op  = !req_write && (req_size == SZ_2) &&
                        (req_addr[11:0] == OP_OFF[OP_ACK]) && (pg <= OP_PAGE[OP_ACK]);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_short_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[11] && (req_size < SZ_4) && !is_prio_op) |=> rsp_err);

    assert_user_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[11] && (req_addr[5:4] == 2'b00)) |=> rsp_err);

    assert_reject_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !$past(req_write)) |-> (rsp_rdata == '1));

    assert_write_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_write)) |-> (rsp_rdata == '0));

    assert_spc_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11] && !is_ack_op) |=> rsp_err);

    assert_prio_clamp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_prio_op) |=>
            (!rsp_err && ((prio_byte <= 8'(MAX_PRIO)) || (prio_byte == 8'hFF))));

    assert_ack_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_ack_op) |=> (!rsp_err && (rsp_rdata == '0)));
endmodule

bind irq_ctx_window irq_ctx_window_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_LSB (PAGE_LSB),
    .MAX_PRIO (MAX_PRIO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .prio_byte (ctx_flat[8*irq_ctx_pkg::PRIO_IDX +: 8])
);

// File: tb/irq_ctx_window_test.sv
module irq_ctx_window_test;
    localparam logic [17:0] H = 18'h00000;
    localparam logic [17:0] V = 18'h10000;
    localparam logic [17:0] O = 18'h20000;
    localparam logic [17:0] U = 18'h30000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [17:0] addr;
        logic [63:0] wd;
        logic        err;
        logic [63:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd3, H|18'h010, 64'h0, 1'b0, 64'h000000FFFF000000, 8'd1},  // R1 reset pattern
        '{1'b0, 2'd2, H|18'h000, 64'h0, 1'b1, ONES, 8'd5},                  // R5 user ring
        '{1'b0, 2'd2, H|18'h012, 64'h0, 1'b1, ONES, 8'd4},                  // R4 misaligned
        '{1'b0, 2'd1, H|18'h010, 64'h0, 1'b1, ONES, 8'd4},                  // R4 2-byte raw
        '{1'b1, 2'd3, H|18'h030, 64'h1122334455667788, 1'b0, 64'h0, 8'd9},  // R9 masked write
        '{1'b0, 2'd3, H|18'h030, 64'h0, 1'b0, 64'h1122334400660088, 8'd8},  // R8 masked read
        '{1'b0, 2'd2, O|18'h020, 64'h0, 1'b1, ONES, 8'd6},                  // R6 nothing readable
        '{1'b1, 2'd2, O|18'h020, 64'hAAAAAAAA, 1'b1, 64'h0, 8'd7},          // R7 rejected write
        '{1'b1, 2'd3, H|18'h010, 64'h0102030405060708, 1'b0, 64'h0, 8'd9},  // R9
        '{1'b0, 2'd3, O|18'h010, 64'h0, 1'b0, 64'h0102030405060008, 8'd14}, // R14 OS view
        '{1'b1, 2'd3, O|18'h010, 64'hF0F1F2F3F4F5F6F7, 1'b0, 64'h0, 8'd9},  // R9 one byte
        '{1'b0, 2'd3, O|18'h010, 64'h0, 1'b0, 64'h01F1030405060008, 8'd9},  // R9
        '{1'b1, 2'd0, O|18'h011, 64'h05, 1'b0, 64'h0, 8'd12},               // R12
        '{1'b0, 2'd2, O|18'h010, 64'h0, 1'b0, 64'h01050304, 8'd12},         // R12
        '{1'b1, 2'd0, H|18'h011, 64'h09, 1'b0, 64'h0, 8'd12},               // R12 clamp
        '{1'b0, 2'd2, V|18'h010, 64'h0, 1'b0, 64'h01FF0304, 8'd12},         // R12
        '{1'b1, 2'd0, U|18'h011, 64'h03, 1'b1, 64'h0, 8'd11},               // R11 page too low
        '{1'b0, 2'd2, H|18'h010, 64'h0, 1'b0, 64'h01FF0304, 8'd11},         // R11 unchanged
        '{1'b0, 2'd1, O|18'h810, 64'h0, 1'b0, 64'h0, 8'd13},                // R13
        '{1'b0, 2'd1, H|18'h810, 64'h0, 1'b0, 64'h0, 8'd13},                // R13 higher page
        '{1'b0, 2'd1, U|18'h810, 64'h0, 1'b1, ONES, 8'd11},                 // R11
        '{1'b0, 2'd2, O|18'h810, 64'h0, 1'b1, ONES, 8'd10},                 // R10 size miss
        '{1'b1, 2'd1, O|18'h810, 64'h0, 1'b1, 64'h0, 8'd10},                // R10 direction miss
        '{1'b0, 2'd3, H|18'h830, 64'h0, 1'b1, ONES, 8'd10},                 // R10 no raw path
        '{1'b0, 2'd3, U|18'h030, 64'h0, 1'b1, ONES, 8'd14},                 // R14 user view
        '{1'b1, 2'd2, H|18'h03C, 64'hA1A2A3A4, 1'b0, 64'h0, 8'd9},          // R9
        '{1'b0, 2'd2, H|18'h03C, 64'h0, 1'b0, 64'hA1A2A300, 8'd3},          // R3
        '{1'b0, 2'd2, V|18'h03C, 64'h0, 1'b1, ONES, 8'd3},                  // R3 HV closed
        '{1'b1, 2'd2, H|18'h028, 64'hB1B2B3B4, 1'b0, 64'h0, 8'd9},          // R9
        '{1'b0, 2'd2, V|18'h028, 64'h0, 1'b0, 64'h00B2B3B4, 8'd3},          // R3
        '{1'b0, 2'd2, H|18'h028, 64'h0, 1'b0, 64'hB1B2B3B4, 8'd3},          // R3
        '{1'b1, 2'd0, O|18'h011, 64'h07, 1'b0, 64'h0, 8'd12},               // R12 edge kept
        '{1'b0, 2'd2, O|18'h010, 64'h0, 1'b0, 64'h01070304, 8'd12},         // R12
        '{1'b0, 2'd2, O|18'h018, 64'h0, 1'b1, ONES, 8'd6},                  // R6
        '{1'b0, 2'd2, 18'h0F010, 64'h0, 1'b0, 64'h01070304, 8'd3},          // R3 alias bits
        '{1'b1, 2'd0, O|18'h011, 64'h08, 1'b0, 64'h0, 8'd12},               // R12 edge+1
        '{1'b0, 2'd2, O|18'h010, 64'h0, 1'b0, 64'h01FF0304, 8'd12}          // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [17:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  reported = 1'b0;

    always #4 clk = ~clk;

    irq_ctx_window uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic check(input string rq, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual={valid,err,data}=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [1:0] sz, input logic [17:0] ad,
                         input logic [63:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = sz;
        req_addr  = ad;
        req_wdata = wd;
    endtask

    task automatic one_req(input logic wr, input logic [1:0] sz, input logic [17:0] ad,
                           input logic [63:0] wd);
        @(negedge clk);
        drive(wr, sz, ad, wd);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        // R1: outputs idle in and after reset
        repeat (2) @(negedge clk);
        check("R1", {rsp_valid, rsp_err, rsp_rdata}, {1'b0, 1'b0, 64'h0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rsp_valid, rsp_err, rsp_rdata}, {1'b0, 1'b0, 64'h0});

        for (int k = 0; k < NV; k++) begin
            one_req(VECS[k].wr, VECS[k].sz, VECS[k].addr, VECS[k].wd);
            check($sformatf("R%0d vec%0d", VECS[k].req, k),
                  {rsp_valid, rsp_err, rsp_rdata}, {1'b1, VECS[k].err, VECS[k].rd});
        end

        // R2: back-to-back requests, then idle
        @(negedge clk);
        drive(1'b0, 2'd2, H|18'h010, 64'h0);
        @(negedge clk);
        check("R2 first", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 64'h01FF0304});
        drive(1'b0, 2'd2, V|18'h03C, 64'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 second", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b1, ONES});
        @(negedge clk);
        check("R2 idle", {rsp_valid, rsp_err, rsp_rdata}, {1'b0, 1'b0, 64'h0});

        // R1: reset in mid-run restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {rsp_valid, rsp_err, rsp_rdata}, {1'b0, 1'b0, 64'h0});
        one_req(1'b0, 2'd3, H|18'h010, 64'h0);
        check("R1 OS ring", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 64'h000000FFFF000000});
        one_req(1'b0, 2'd3, H|18'h030, 64'h0);
        check("R1 phys ring", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 64'h0});
        one_req(1'b0, 2'd2, H|18'h028, 64'h0);
        check("R1 pool ring", {rsp_valid, rsp_err, rsp_rdata}, {1'b1, 1'b0, 64'h0});

        report();
        $finish;
    end
endmodule